// File: doc/BRIEF.md
# Four-Function Arithmetic/Logic Unit

This block is the arithmetic/logic unit of a simple processor datapath. It takes two operands and a 2-bit operation code. It returns a result word and a signed-overflow flag. It holds no state: every output is a pure function of the present inputs.

Inside there are three function units that run side by side on the same operands:
- one carry-chain unit shared by addition and subtraction;
- a bitwise AND array;
- a bitwise OR array.

A two-level selection picks the output. The upper bit of the operation code chooses arithmetic or logic. The lower bit serves two roles: it chooses OR over AND, and it puts the shared unit into subtract mode.

Subtraction is formed as A + ~B + 1. The operands and the result have no handshake, because there is no storage to apply back-pressure to. The block sits between a register read stage and a write-back stage of the surrounding pipeline.

Top module: `alu4`

## Requirements
- R1: With op_sel = 2'b00, result equals (op_a + op_b) modulo 2^WIDTH.
- R2: With op_sel = 2'b01, result equals (op_a - op_b) modulo 2^WIDTH; for example, 0x80000000 - 1 gives 0x7FFFFFFF.
- R3: With op_sel = 2'b10, result equals op_a AND op_b, computed bit by bit.
- R4: With op_sel = 2'b11, result equals op_a OR op_b, computed bit by bit.
- R5: With op_sel = 2'b00, ovf is 1 exactly when op_a and op_b have the same sign (bit WIDTH-1) and the result sign differs from it; for example, 0x7FFFFFFF + 1 gives ovf = 1.
- R6: With op_sel = 2'b01, ovf is 1 exactly when op_a and op_b differ in sign and the result sign differs from op_a's sign. For example, 0 - 0x80000000 gives ovf = 1, while 0x80000000 - 0x80000000 gives 0 with ovf = 0.
- R7: With op_sel[1] = 1 (a logic operation), ovf is 0 whatever the operands.
- R8: The outputs depend only on the present inputs, with no clock. A change of op_sel alone, with the operands held, moves result to the newly selected function in the same time step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH (32) | First operand |
| op_b | input | WIDTH (32) | Second operand; it is the subtrahend when subtracting |
| op_sel | input | 2 | Operation code: 00 add, 01 subtract, 10 AND, 11 OR |
| result | output | WIDTH (32) | Selected function result |
| ovf | output | 1 | Signed overflow of the add or subtract; 0 for logic operations |

## Verification
The block has no internal state, so any fault shows at the ports in the same time step as the inputs that expose it.

Different faults surface in different places:
- A broken carry link shows as a wrong result bit only for operand pairs whose carry crosses that position.
- A mis-wired subtract control shows as an off-by-one or inverted-operand result under code 01.
- A fault in the overflow tap shows only at the signed boundaries.

To cover these, every operand pair and code of a 4-bit instance is swept exhaustively, and the 32-bit instance is driven with the four signed boundary cases plus random operands.

// File: rtl/alu4_pkg.sv
package alu4_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_AND = 2'b10,
    OP_OR  = 2'b11
  } alu_op_e;

  // bit positions inside the operation code
  localparam int unsigned SEL_FLAVOUR = 0;  // sub mode / OR pick
  localparam int unsigned SEL_CLASS   = 1;  // logic vs arithmetic

endpackage

// File: rtl/alu4_addsub.sv
module alu4_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             ovf_o
);

  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] b_eff;

  // subtract control enters both the operand inversion and the carry-in
  assign carry[0] = sub_i;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      assign b_eff[gi]    = b_i[gi] ^ sub_i;
      assign sum_o[gi]    = a_i[gi] ^ b_eff[gi] ^ carry[gi];
      assign carry[gi+1]  = (a_i[gi] & b_eff[gi]) |
                            (a_i[gi] & carry[gi]) |
                            (b_eff[gi] & carry[gi]);
    end
  endgenerate

  // signed overflow: carry into the top bit disagrees with carry out of it
  assign ovf_o = carry[MSB] ^ carry[WIDTH];

endmodule

// File: rtl/alu4_logic.sv
module alu4_logic #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             pick_or_i,
  output logic [WIDTH-1:0] y_o
);

  logic [WIDTH-1:0] and_v;
  logic [WIDTH-1:0] or_v;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      assign and_v[gi] = a_i[gi] & b_i[gi];
      assign or_v[gi]  = a_i[gi] | b_i[gi];
      assign y_o[gi]   = pick_or_i ? or_v[gi] : and_v[gi];
    end
  endgenerate

endmodule

// File: rtl/alu4_resmux.sv
module alu4_resmux #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             logic_sel_i,
  input  logic [WIDTH-1:0] arith_i,
  input  logic             arith_ovf_i,
  input  logic [WIDTH-1:0] logic_i,
  output logic [WIDTH-1:0] y_o,
  output logic             ovf_o
);

  always_comb begin
    if (logic_sel_i) begin
      y_o   = logic_i;
      ovf_o = 1'b0;
    end else begin
      y_o   = arith_i;
      ovf_o = arith_ovf_i;
    end
  end

endmodule

// File: rtl/alu4.sv
module alu4
  import alu4_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             ovf
);

  logic [WIDTH-1:0] arith_y;
  logic             arith_v;
  logic [WIDTH-1:0] logic_y;

  alu4_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a_i   (op_a),
    .b_i   (op_b),
    .sub_i (op_sel[SEL_FLAVOUR]),
    .sum_o (arith_y),
    .ovf_o (arith_v)
  );

  alu4_logic #(.WIDTH(WIDTH)) u_logic (
    .a_i       (op_a),
    .b_i       (op_b),
    .pick_or_i (op_sel[SEL_FLAVOUR]),
    .y_o       (logic_y)
  );

  alu4_resmux #(.WIDTH(WIDTH)) u_resmux (
    .logic_sel_i (op_sel[SEL_CLASS]),
    .arith_i     (arith_y),
    .arith_ovf_i (arith_v),
    .logic_i     (logic_y),
    .y_o         (result),
    .ovf_o       (ovf)
  );

endmodule

// File: rtl/alu4_chk.sv
module alu4_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [1:0]       op_sel,
  input logic [WIDTH-1:0] result,
  input logic             ovf
);

  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] ref_sum;
  logic [WIDTH-1:0] ref_dif;
  logic             known;

  always_comb begin
    ref_sum = op_a + op_b;
    ref_dif = op_a - op_b;
    known   = !$isunknown({op_a, op_b, op_sel, result, ovf});
    if (known) begin
      if (op_sel == 2'b00) begin
        p_add_r1: assert (result == ref_sum) else $error("add result mismatch");
        p_add_ovf_r5: assert (ovf == ((op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB])))
          else $error("add overflow mismatch");
      end
      if (op_sel == 2'b01) begin
        p_sub_r2: assert (result == ref_dif) else $error("sub result mismatch");
        p_sub_ovf_r6: assert (ovf == ((op_a[MSB] != op_b[MSB]) && (result[MSB] != op_a[MSB])))
          else $error("sub overflow mismatch");
      end
      if (op_sel == 2'b10) begin
        p_and_r3: assert (result == (op_a & op_b)) else $error("and mismatch");
      end
      if (op_sel == 2'b11) begin
        p_or_r4: assert (result == (op_a | op_b)) else $error("or mismatch");
      end
      if (op_sel[1]) begin
        p_no_overflow_r7: assert (!ovf) else $error("overflow on logic op");
      end
    end
  end

endmodule

bind alu4 alu4_chk #(.WIDTH(WIDTH)) u_chk (
  .op_a   (op_a),
  .op_b   (op_b),
  .op_sel (op_sel),
  .result (result),
  .ovf    (ovf)
);

// File: tb/alu4_tb.sv
module alu4_tb;

  localparam int unsigned W  = 32;
  localparam int unsigned WS = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [W-1:0]  a, b;
  logic [1:0]    sel;
  logic [W-1:0]  r;
  logic          v;

  logic [WS-1:0] sa, sb;
  logic [1:0]    ssel;
  logic [WS-1:0] sr;
  logic          sv;

  alu4 #(.WIDTH(W)) u_dut (
    .op_a(a), .op_b(b), .op_sel(sel), .result(r), .ovf(v)
  );

  alu4 #(.WIDTH(WS)) u_dut_small (
    .op_a(sa), .op_b(sb), .op_sel(ssel), .result(sr), .ovf(sv)
  );

  function automatic void model(input int unsigned w, input longint unsigned xa,
                                input longint unsigned xb, input int unsigned s,
                                output longint unsigned rr, output bit vv);
    longint unsigned mask = (64'd1 << w) - 1;
    longint sxa = longint'(xa);
    longint sxb = longint'(xb);
    longint full;
    longint maxv = (64'sd1 <<< (w - 1)) - 1;
    longint minv = -(64'sd1 <<< (w - 1));
    if (xa[w-1]) sxa = sxa - (64'sd1 <<< w);
    if (xb[w-1]) sxb = sxb - (64'sd1 <<< w);
    vv = 1'b0;
    case (s)
      0: begin full = sxa + sxb; rr = longint'(full) & mask; vv = (full > maxv) || (full < minv); end
      1: begin full = sxa - sxb; rr = longint'(full) & mask; vv = (full > maxv) || (full < minv); end
      2: rr = xa & xb;
      default: rr = xa | xb;
    endcase
  endfunction

  function automatic string res_tag(input int unsigned s);
    case (s)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic string ovf_tag(input int unsigned s);
    case (s)
      0: return "R5";
      1: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input longint unsigned got, input longint unsigned exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run_big(input logic [W-1:0] xa, input logic [W-1:0] xb, input logic [1:0] s);
    longint unsigned er;
    bit ev;
    @(posedge clk);
    #1;
    a = xa; b = xb; sel = s;
    @(negedge clk);
    model(W, longint'(xa), longint'(xb), s, er, ev);
    check(res_tag(s), r, er);
    check(ovf_tag(s), v, ev);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    longint unsigned er;
    bit ev;
    a = '0; b = '0; sel = 2'b00;
    sa = '0; sb = '0; ssel = 2'b00;
    @(negedge clk);
    // idle inputs: 0 + 0 gives zero and no overflow (R1, R5)
    check("R1", r, 0);
    check("R5", v, 0);

    // signed boundary cases
    run_big(32'h7FFF_FFFF, 32'h0000_0001, 2'b00); // R5 overflow set
    run_big(32'h8000_0000, 32'h0000_0001, 2'b01); // R2/R6 wrap
    run_big(32'h8000_0000, 32'h8000_0000, 2'b01); // R6 no overflow
    run_big(32'h0000_0000, 32'h8000_0000, 2'b01); // R6 overflow set
    run_big(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b00); // R1 negative + negative
    run_big(32'h8000_0000, 32'h8000_0000, 2'b00); // R5 overflow set
    run_big(32'hFFFF_FFFF, 32'h8000_0000, 2'b11); // R7 no flag on OR
    run_big(32'hA5A5_A5A5, 32'h0F0F_0F0F, 2'b10); // R3

    // random operands on every code
    for (int i = 0; i < 1500; i++) begin
      run_big($urandom, $urandom, 2'($urandom_range(0, 3)));
    end

    // R8: operands held, only the code moves, outputs follow in the same step
    @(posedge clk);
    #1;
    a = 32'h1234_5678; b = 32'h0F0F_F0F0;
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      #1;
      model(W, longint'(a), longint'(b), s, er, ev);
      check("R8", r, er);
      check("R8", v, ev);
    end

    // exhaustive sweep of the narrow instance
    for (int s = 0; s < 4; s++) begin
      for (int x = 0; x < (1 << WS); x++) begin
        for (int y = 0; y < (1 << WS); y++) begin
          @(posedge clk);
          #1;
          sa = WS'(x); sb = WS'(y); ssel = 2'(s);
          @(negedge clk);
          model(WS, longint'(x), longint'(y), s, er, ev);
          check(res_tag(s), sr, er);
          check(ovf_tag(s), sv, ev);
        end
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule